// File: doc/BRIEF.md
# I2C Bus Master with Command-Bit Sequencing

This block is a single-owner I2C bus master. Software picks each bus cycle by writing a combination of command bits to a control input: run, start, stop and acknowledge-enable. Separate write strobes load a slave-address register and a transmit-data register. Bits 7..1 of the slave-address register hold the 7-bit address and bit 0 is the direction (1 = read). The receive register is output as `rxd`. A cycle can open with a START, or with a repeated START when the master still owns the bus. It then moves one address and/or one data byte, and finishes by releasing the bus with a STOP or by parking it with SCL held low for the next command. An interrupt flag rises when a cycle completes or when a slave not-acknowledge aborts it.

The control byte is laid out as follows: bit0 = run, bit1 = start, bit2 = stop, bit3 = acknowledge enable, bits 6..4 reserved (must be zero), bit7 = soft reset. Both bus lines are open-drain. The outputs `scl_drv_low` and `sda_drv_low` mean "pull the line low", and `sda_in` is the resolved SDA line. Every bus bit lasts four quarter phases of `QDIV` clocks each: SCL low, SCL low, SCL high, SCL high.

The sequencer states are IDLE, START, BYTE, ACK, STOP and PARK. Its transitions are:
- IDLE→START on a start command.
- IDLE→BYTE on a data-only command while the bus is held.
- IDLE→STOP on a stop-only command while the bus is held.
- START→BYTE after the start condition.
- BYTE→ACK after the last bit.
- ACK→BYTE after an acknowledged address.
- ACK→STOP on a slave not-acknowledge, or when the stop bit was set.
- ACK→PARK when the stop bit was clear.
- STOP→IDLE after the stop condition.
- PARK→IDLE once SCL is low and SDA is released.
- Any state→IDLE on soft reset.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, and whenever no cycle runs and the bus is not held, busy, irq, err and bus_held are 0 and both line drivers are released.
- R2: A control write of 0x07 (run, start, stop) from idle produces START, the address byte, one data byte from the transmit register, and STOP. The slave acknowledges with SDA low in the ninth bit.
- R3: A start command issued while the bus is held produces a repeated START (SDA falls while SCL is high) with no STOP before it.
- R4: When stop is 0 the cycle ends with the bus held. bus_held is 1 and SCL is driven low until the next cycle.
- R5: A control write with run=1 and start=0 while the bus is held moves one data byte with no START and no address. Its direction follows bit 0 of the last address sent.
- R6: In a read data byte, acknowledge enable 1 makes the master pull SDA low in the ninth bit, and 0 leaves SDA high (not-acknowledge). The received byte then appears on rxd.
- R7: When SDA is high in the ninth bit after the address or after a written data byte, err is set, together with addr_nack or data_nack. A STOP is issued whatever the stop bit says, and irq is set.
- R8: irq rises when a cycle completes. Any idle control write with bit7=0 clears it.
- R9: A control write with bit7=1 aborts any cycle at once. It releases both lines and clears busy, irq, err and bus_held.
- R10: Control writes with bit7=0 are ignored while busy is 1, and so are writes with any of bits 6..4 set.
- R11: SCL rises exactly every 4*QDIV clocks within a transfer. SDA changes while SCL is high only to form START or STOP.
- R12: A control write with run=0 and stop=1 while the bus is held issues only a STOP. Run=1 with start=0 on a free bus starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wd | input | 8 | Control byte: run, start, stop, ack enable, reserved, soft reset |
| sla_we | input | 1 | Slave-address register write strobe |
| sla_wd | input | DW | Address in bits 7..1, read select in bit 0 |
| txd_we | input | 1 | Transmit register write strobe |
| txd_wd | input | DW | Transmit byte |
| rxd | output | DW | Last received byte |
| busy | output | 1 | A bus cycle is running |
| err | output | 1 | Last cycle ended on a not-acknowledge |
| addr_nack | output | 1 | Address was not acknowledged |
| data_nack | output | 1 | Written data byte was not acknowledged |
| bus_held | output | 1 | Bus owned without a STOP |
| irq | output | 1 | Cycle-complete interrupt flag |
| scl_drv_low | output | 1 | Pull SCL low |
| sda_drv_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
A behavioural slave at address 0x2A decodes START, STOP and every nine-bit group from the resolved lines into an event queue. That queue is compared with sequences built from the requirements. The command patterns are: full write with stop; held write; a data-only byte on the held bus; repeated-start read with acknowledge; data-only read with not-acknowledge; stop-only; and run without start on a free bus. Each pattern separates address-phase, repeated-start and stop/park decisions that the others cannot tell apart. The not-acknowledge patterns (unknown address, data byte 0xFF with stop clear) tell a forced STOP from a requested one. A soft reset in mid-address, followed by a fresh transfer, shows that the abort leaves no residue.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BYTE,
        ST_ACK,
        ST_STOP,
        ST_PARK
    } mst_state_t;

    localparam int CB_RUN   = 0;
    localparam int CB_START = 1;
    localparam int CB_STOP  = 2;
    localparam int CB_ACK   = 3;
    localparam int CB_RSV_LO = 4;
    localparam int CB_RSV_HI = 6;
    localparam int CB_SRST  = 7;

endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST) && !restart;
endmodule

// File: rtl/i2c_byte_shreg.sv
module i2c_byte_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int QDIV = 4,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wd,
    input  logic          sla_we,
    input  logic [DW-1:0] sla_wd,
    input  logic          txd_we,
    input  logic [DW-1:0] txd_wd,
    output logic [DW-1:0] rxd,
    output logic          busy,
    output logic          err,
    output logic          addr_nack,
    output logic          data_nack,
    output logic          bus_held,
    output logic          irq,
    output logic          scl_drv_low,
    output logic          sda_drv_low,
    input  logic          sda_in
);
    localparam int BCW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] BIT_LAST = BCW'(DW - 1);

    mst_state_t     state, state_n;
    logic [1:0]     phase, phase_n;
    logic           tick;
    logic [BCW-1:0] bit_cnt;
    logic [DW-1:0]  sla_q, txd_q, sh_q, sh_din;
    logic           ack_en, stop_en, last_rd, cur_rd, is_addr, nack_q, held_q;
    logic           srst, cmd_ok, clr_irq, go_start, go_data, go_stop, launch;
    logic           last_ph, nack_now, byte_last, sh_load, sh_shift, fin;

    // command decode
    assign srst     = ctl_we && ctl_wd[CB_SRST];
    assign clr_irq  = ctl_we && !ctl_wd[CB_SRST] && (state == ST_IDLE);
    assign cmd_ok   = clr_irq && (ctl_wd[CB_RSV_HI:CB_RSV_LO] == '0);
    assign go_start = cmd_ok && ctl_wd[CB_RUN] && ctl_wd[CB_START];
    assign go_data  = cmd_ok && ctl_wd[CB_RUN] && !ctl_wd[CB_START] && held_q;
    assign go_stop  = cmd_ok && !ctl_wd[CB_RUN] && ctl_wd[CB_STOP] && held_q;
    assign launch   = go_start || go_data || go_stop;

    assign last_ph   = tick && (phase == 2'd3);
    assign nack_now  = nack_q && (is_addr || !cur_rd);
    assign byte_last = (bit_cnt == BIT_LAST);
    assign fin       = (state == ST_STOP && last_ph) ||
                       (state == ST_PARK && tick && phase == 2'd1);

    assign sh_load  = go_start || go_data ||
                      (state == ST_ACK && last_ph && is_addr && !nack_now);
    assign sh_din   = go_start ? sla_q : txd_q;
    assign sh_shift = (state == ST_BYTE) && tick && (phase == 2'd2);

    i2c_qtr_timer #(.QDIV(QDIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch || srst),
        .tick    (tick)
    );

    i2c_byte_shreg #(.W(DW)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .din    (sh_din),
        .shift  (sh_shift),
        .bit_in (sda_in),
        .q      (sh_q)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        phase_n = phase;
        unique case (state)
            ST_IDLE: begin
                phase_n = 2'd0;
                if (go_start)     state_n = ST_START;
                else if (go_data) state_n = ST_BYTE;
                else if (go_stop) state_n = ST_STOP;
            end
            ST_START, ST_BYTE, ST_ACK, ST_STOP: begin
                if (tick) phase_n = phase + 2'd1;
                if (last_ph) begin
                    unique case (state)
                        ST_START: state_n = ST_BYTE;
                        ST_BYTE:  if (byte_last) state_n = ST_ACK;
                        ST_ACK: begin
                            if (nack_now)     state_n = ST_STOP;
                            else if (is_addr) state_n = ST_BYTE;
                            else if (stop_en) state_n = ST_STOP;
                            else              state_n = ST_PARK;
                        end
                        default:  state_n = ST_IDLE;
                    endcase
                end
            end
            ST_PARK: begin
                if (tick) phase_n = phase + 2'd1;
                if (fin) begin
                    state_n = ST_IDLE;
                    phase_n = 2'd0;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (srst) begin
            state_n = ST_IDLE;
            phase_n = 2'd0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 2'd0;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end

    // cycle context and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sla_q <= '0; txd_q <= '0; rxd <= '0; bit_cnt <= '0;
            ack_en <= 1'b0; stop_en <= 1'b0; last_rd <= 1'b0; cur_rd <= 1'b0;
            is_addr <= 1'b0; nack_q <= 1'b0; held_q <= 1'b0;
            err <= 1'b0; addr_nack <= 1'b0; data_nack <= 1'b0; irq <= 1'b0;
        end else if (srst) begin
            sla_q <= '0; txd_q <= '0; rxd <= '0; bit_cnt <= '0;
            ack_en <= 1'b0; stop_en <= 1'b0; last_rd <= 1'b0; cur_rd <= 1'b0;
            is_addr <= 1'b0; nack_q <= 1'b0; held_q <= 1'b0;
            err <= 1'b0; addr_nack <= 1'b0; data_nack <= 1'b0; irq <= 1'b0;
        end else begin
            if (sla_we) sla_q <= sla_wd;
            if (txd_we) txd_q <= txd_wd;
            if (clr_irq) irq <= 1'b0;
            if (launch) begin
                ack_en    <= ctl_wd[CB_ACK];
                stop_en   <= ctl_wd[CB_STOP];
                err       <= 1'b0;
                addr_nack <= 1'b0;
                data_nack <= 1'b0;
                bit_cnt   <= '0;
            end
            if (go_start) begin
                is_addr <= 1'b1;
                cur_rd  <= sla_q[0];
                last_rd <= sla_q[0];
            end
            if (go_data) begin
                is_addr <= 1'b0;
                cur_rd  <= last_rd;
            end
            if (state == ST_BYTE && last_ph) begin
                bit_cnt <= byte_last ? '0 : bit_cnt + 1'b1;
                if (byte_last && cur_rd && !is_addr) rxd <= sh_q;
            end
            if (state == ST_ACK && tick && phase == 2'd2) nack_q <= sda_in;
            if (state == ST_ACK && last_ph) begin
                if (nack_now) begin
                    err       <= 1'b1;
                    addr_nack <= is_addr;
                    data_nack <= !is_addr;
                end else if (is_addr) begin
                    is_addr <= 1'b0;
                end
            end
            if (fin) begin
                irq    <= 1'b1;
                held_q <= (state == ST_PARK);
            end
        end
    end

    // line drivers, set for the phase being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_drv_low <= 1'b0;
            sda_drv_low <= 1'b0;
        end else if (srst) begin
            scl_drv_low <= 1'b0;
            sda_drv_low <= 1'b0;
        end else if (tick && state != ST_IDLE) begin
            unique case (state_n)
                ST_START: begin
                    if (phase_n == 2'd1) begin scl_drv_low <= 1'b0; sda_drv_low <= 1'b0; end
                    if (phase_n == 2'd2) sda_drv_low <= 1'b1;
                    if (phase_n == 2'd3) scl_drv_low <= 1'b1;
                end
                ST_BYTE: begin
                    if (phase_n == 2'd0) scl_drv_low <= 1'b1;
                    if (phase_n == 2'd1) sda_drv_low <= (cur_rd && !is_addr) ? 1'b0 : !sh_q[DW-1];
                    if (phase_n == 2'd2) scl_drv_low <= 1'b0;
                end
                ST_ACK: begin
                    if (phase_n == 2'd0) scl_drv_low <= 1'b1;
                    if (phase_n == 2'd1) sda_drv_low <= (cur_rd && !is_addr) ? ack_en : 1'b0;
                    if (phase_n == 2'd2) scl_drv_low <= 1'b0;
                end
                ST_STOP: begin
                    if (phase_n == 2'd0) scl_drv_low <= 1'b1;
                    if (phase_n == 2'd1) sda_drv_low <= 1'b1;
                    if (phase_n == 2'd2) scl_drv_low <= 1'b0;
                    if (phase_n == 2'd3) sda_drv_low <= 1'b0;
                end
                ST_PARK: begin
                    if (phase_n == 2'd0) scl_drv_low <= 1'b1;
                    if (phase_n == 2'd1) sda_drv_low <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign bus_held = held_q;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
    import i2c_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_wd,
    input logic       busy,
    input logic       err,
    input logic       addr_nack,
    input logic       data_nack,
    input logic       bus_held,
    input logic       irq,
    input logic       scl_drv_low,
    input logic       sda_drv_low,
    input mst_state_t state
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drv_low && $past(!scl_drv_low) && (sda_drv_low != $past(sda_drv_low))
         && !$past(ctl_we && ctl_wd[CB_SRST])) |-> (state == ST_START || state == ST_STOP)); // R11

    AST_IRQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R8

    AST_ERROR_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy) |-> !bus_held); // R7

    AST_NACK_HAS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_nack || data_nack) |-> (err && $onehot0({addr_nack, data_nack}))); // R7

    AST_HELD_KEEPS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_held && !busy) |-> scl_drv_low); // R4

    AST_FREE_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_held && !busy) |-> (!scl_drv_low && !sda_drv_low)); // R1

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wd[CB_SRST]) |=> (!busy && !irq && !bus_held && !err
                                         && !scl_drv_low && !sda_drv_low)); // R9
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wd      (ctl_wd),
    .busy        (busy),
    .err         (err),
    .addr_nack   (addr_nack),
    .data_nack   (data_nack),
    .bus_held    (bus_held),
    .irq         (irq),
    .scl_drv_low (scl_drv_low),
    .sda_drv_low (sda_drv_low),
    .state       (state)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
    localparam int QDIV = 3;
    localparam int DW   = 8;
    localparam logic [6:0] SLV = 7'h2A;
    localparam int EV_S = -1;
    localparam int EV_P = -2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0, sla_we = 1'b0, txd_we = 1'b0;
    logic [7:0] ctl_wd = '0, sla_wd = '0, txd_wd = '0;
    logic [7:0] rxd;
    logic busy, err, addr_nack, data_nack, bus_held, irq, scl_drv_low, sda_drv_low;
    logic sl_low = 1'b0;
    logic sda_line;

    assign sda_line = !(sda_drv_low || sl_low);

    always #4 clk = !clk;

    i2c_cmd_master #(.QDIV(QDIV), .DW(DW)) i_i2c_cmd_master (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wd(ctl_wd),
        .sla_we(sla_we), .sla_wd(sla_wd),
        .txd_we(txd_we), .txd_wd(txd_wd),
        .rxd(rxd), .busy(busy), .err(err), .addr_nack(addr_nack),
        .data_nack(data_nack), .bus_held(bus_held), .irq(irq),
        .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
        .sda_in(sda_line)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int evq[$];
    int exq[$];
    int rise_t[$];
    int srst_cnt = 0;
    int m_checks = 0;
    int m_errors = 0;

    function automatic int ev(input logic [7:0] b, input logic a);
        return int'(b) * 2 + int'(a);
    endfunction

    function automatic logic [7:0] rd_mem(input int idx);
        if (idx == 0) return 8'hA7;
        if (idx == 1) return 8'h3C;
        return 8'h00;
    endfunction

    // behavioural slave, bus monitor and per-clock ownership model
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] sh = '0, wr_last = '0;
    int bitn = 0, rd_idx = 0, seen_srst = 0;
    logic first = 1'b0, addressed = 1'b0, rd_go = 1'b0, owned = 1'b0;

    always @(negedge clk) begin
        logic scl, sda;
        cyc++;
        scl = !scl_drv_low;
        sda = sda_line;
        if (seen_srst != srst_cnt) begin
            seen_srst = srst_cnt;
            owned = 1'b0;
        end
        if (rst_n) begin
            if (prev_scl && scl && prev_sda && !sda) begin
                evq.push_back(EV_S); bitn = 0; first = 1'b1; addressed = 1'b0;
                rd_go = 1'b0; sl_low = 1'b0; owned = 1'b1;
            end else if (prev_scl && scl && !prev_sda && sda) begin
                evq.push_back(EV_P); rd_go = 1'b0; sl_low = 1'b0; owned = 1'b0;
            end else if (!prev_scl && scl) begin
                rise_t.push_back(cyc);
                if (bitn < 8) begin
                    sh = {sh[6:0], sda}; bitn++;
                end else begin
                    evq.push_back(ev(sh, sda));
                    if (first) begin
                        first = 1'b0;
                        addressed = (sh[7:1] == SLV);
                        rd_go = addressed && sh[0] && !sda;
                    end else if (rd_go) begin
                        rd_idx++; rd_go = !sda;
                    end else if (addressed) begin
                        wr_last = sh;
                    end
                    bitn = 0;
                end
            end else if (prev_scl && !scl) begin
                sl_low = 1'b0;
                if (bitn == 8) begin
                    if (first) sl_low = (sh[7:1] == SLV);
                    else if (addressed && !rd_go) sl_low = (sh != 8'hFF);
                end else if (rd_go) begin
                    sl_low = !rd_mem(rd_idx)[7 - bitn];
                end
            end
            // R4: outside a cycle, held status and SCL follow bus ownership
            if (!busy) begin
                m_checks++;
                if (bus_held !== owned || scl_drv_low !== owned) begin
                    m_errors++;
                    $display("FAIL R4 cycle %0d: held=%0b scl_low=%0b expected %0b",
                             cyc, bus_held, scl_drv_low, owned);
                end
            end
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errors + m_errors + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wd = d;
        if (d[7]) srst_cnt++;
        @(negedge clk); ctl_we = 1'b0; ctl_wd = '0;
    endtask

    task automatic wr_sla(input logic [7:0] d);
        @(negedge clk); sla_we = 1'b1; sla_wd = d;
        @(negedge clk); sla_we = 1'b0;
    endtask

    task automatic wr_txd(input logic [7:0] d);
        @(negedge clk); txd_we = 1'b1; txd_wd = d;
        @(negedge clk); txd_we = 1'b0;
    endtask

    task automatic wait_done();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_events(input string req);
        logic ok;
        ok = (evq.size() == exq.size());
        chk(ok, {req, " event count"}, evq.size(), exq.size());
        if (ok) begin
            for (int i = 0; i < exq.size(); i++) begin
                chk(evq[i] == exq[i], {req, " bus event"}, evq[i], exq[i]);
            end
        end
        evq.delete();
        exq.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(!busy && !irq && !err && !bus_held, "R1 status idle", {busy, irq, err, bus_held}, 0);
        chk(!scl_drv_low && !sda_drv_low, "R1 lines released", {scl_drv_low, sda_drv_low}, 0);

        // R2 single write transfer; R11 bit period
        wr_sla({SLV, 1'b0}); wr_txd(8'h5C);
        rise_t.delete();
        wr_ctl(8'h07); wait_done();
        exq = '{EV_S, ev(8'h54, 1'b0), ev(8'h5C, 1'b0), EV_P};
        cmp_events("R2");
        chk(irq && !err && !bus_held, "R2 done flags", {irq, err, bus_held}, 4);
        chk(wr_last == 8'h5C, "R2 slave byte", wr_last, 8'h5C);
        chk(rise_t.size() == 19, "R11 scl rise count", rise_t.size(), 19);
        if (rise_t.size() == 19) begin
            chk(rise_t[1] - rise_t[0] == 4 * QDIV, "R11 bit period", rise_t[1] - rise_t[0], 4 * QDIV);
            chk(rise_t[10] - rise_t[9] == 4 * QDIV, "R11 bit period data", rise_t[10] - rise_t[9], 4 * QDIV);
        end

        // R8 clear irq; write with run=0 starts nothing
        wr_ctl(8'h00); repeat (3) @(negedge clk);
        chk(!irq && !busy, "R8 irq cleared", {irq, busy}, 0);

        // R10 writes while busy ignored, reserved bits ignored
        wr_txd(8'h21); wr_ctl(8'h07);
        repeat (20) @(negedge clk);
        wr_ctl(8'h03); wr_ctl(8'h00);
        wait_done(); repeat (40) @(negedge clk);
        exq = '{EV_S, ev(8'h54, 1'b0), ev(8'h21, 1'b0), EV_P};
        cmp_events("R10 busy write");
        chk(irq, "R10 irq not cleared while busy", irq, 1);
        wr_ctl(8'h17); repeat (40) @(negedge clk);
        chk(!busy && evq.size() == 0, "R10 reserved bits", evq.size(), 0);

        // R7 address not acknowledged, stop bit clear
        wr_sla(8'h66); wr_ctl(8'h03); wait_done();
        exq = '{EV_S, ev(8'h66, 1'b1), EV_P};
        cmp_events("R7 addr");
        chk(err && addr_nack && !data_nack && irq && !bus_held, "R7 addr flags",
            {err, addr_nack, data_nack, irq, bus_held}, 5'b11010);

        // R7 data not acknowledged
        wr_sla({SLV, 1'b0}); wr_txd(8'hFF); wr_ctl(8'h03); wait_done();
        exq = '{EV_S, ev(8'h54, 1'b0), ev(8'hFF, 1'b1), EV_P};
        cmp_events("R7 data");
        chk(err && !addr_nack && data_nack && !bus_held, "R7 data flags",
            {err, addr_nack, data_nack, bus_held}, 4'b1010);

        // R4 held write
        wr_txd(8'h11); wr_ctl(8'h03); wait_done();
        exq = '{EV_S, ev(8'h54, 1'b0), ev(8'h11, 1'b0)};
        cmp_events("R4");
        chk(bus_held && scl_drv_low && irq && !err, "R4 held", {bus_held, scl_drv_low, irq, err}, 4'b1110);

        // R5 data-only write on held bus
        wr_txd(8'h22); wr_ctl(8'h01); wait_done();
        exq = '{ev(8'h22, 1'b0)};
        cmp_events("R5 write");
        chk(bus_held && wr_last == 8'h22, "R5 slave byte", wr_last, 8'h22);

        // R3 repeated start read with acknowledge (R6)
        wr_sla({SLV, 1'b1}); wr_ctl(8'h0B); wait_done();
        exq = '{EV_S, ev(8'h55, 1'b0), ev(8'hA7, 1'b0)};
        cmp_events("R3");
        chk(rxd == 8'hA7, "R6 rx byte acked", rxd, 8'hA7);
        chk(bus_held, "R3 held after read", bus_held, 1);

        // R5 data-only read follows last direction; R6 not-acknowledge
        wr_ctl(8'h05); wait_done();
        exq = '{ev(8'h3C, 1'b1), EV_P};
        cmp_events("R6 nack");
        chk(rxd == 8'h3C && !bus_held && !err, "R5 read byte", rxd, 8'h3C);

        // R12 stop-only on held bus
        wr_sla({SLV, 1'b0}); wr_txd(8'h33); wr_ctl(8'h03); wait_done();
        evq.delete();
        wr_ctl(8'h04); wait_done();
        exq = '{EV_P};
        cmp_events("R12 stop only");
        chk(!bus_held && irq, "R12 released", {bus_held, irq}, 2'b01);

        // R12 run without start on free bus
        wr_ctl(8'h01); repeat (40) @(negedge clk);
        chk(!busy && !irq && evq.size() == 0, "R12 no cycle", evq.size(), 0);

        // R9 soft reset mid-address, then recovery
        wr_txd(8'h44); wr_ctl(8'h07); repeat (25) @(negedge clk);
        chk(busy, "R9 cycle running", busy, 1);
        wr_ctl(8'h80);
        chk(!busy && !irq && !bus_held && !scl_drv_low && !sda_drv_low, "R9 aborted",
            {busy, irq, bus_held, scl_drv_low, sda_drv_low}, 0);
        repeat (10) @(negedge clk);
        evq.delete();
        wr_sla({SLV, 1'b0}); wr_txd(8'h5A); wr_ctl(8'h07); wait_done();
        exq = '{EV_S, ev(8'h54, 1'b0), ev(8'h5A, 1'b0), EV_P};
        cmp_events("R9 recovery");

        $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
        $finish;
    end
endmodule